// File: doc/BRIEF.md
# Display Timing Generator with Mode-Switch Commands

This block produces line and frame timing for a panel: a horizontal counter steps once per clock and a vertical counter steps once per line. Each axis has five programmable values: the period length, the first and the first-past-last count of its sync pulse, and the first and the first-past-last count of its active-pixel window. Each sync pulse has its own polarity select. The registered outputs are the two syncs, a data-enable, a blank-data flag, a command-mode indicator and a busy flag.

A command port takes an 8-bit code and a 2-bit type in a single valid cycle. Only type 00 (display control) acts on the controller. Types 01, 10 and 11 belong to other command paths and are ignored here. Codes 00h and 01h start display output, and 01h also restarts both counters at the frame origin. The other codes move the controller into command mode. Codes 02h and 14h switch at once and halt the timing. Code 15h switches at once but keeps the timing running with pixel data blanked. Codes 12h and 11h wait for the next line or frame sync. Code 13h waits for the next frame sync, sends one black frame, and switches at the sync that follows.

Top module: `lcd_tgen`

## Requirements
- R1: The horizontal counter runs 0 to h_total-1 and the vertical counter advances at each line wrap, running 0 to v_total-1. de_o is high only when both counters lie in their windows [disp_start, disp_end) and the controller is showing data (display mode or waiting on a deferred switch).
- R2: A sync is active while its counter lies in [sync_start, sync_end). The output level is high when active if the axis's polarity input is 1, and low when active if it is 0.
- R3: Every output is registered. The value that appears after clock edge N reflects the counter position and mode in effect before edge N. After a start command (00h, or 01h, which also clears the counters from any mode), counting resumes from zero at the command edge. The first vertical sync therefore appears v_sync_start*h_total+1 edges after the command edge.
- R4: A command with type other than 00 has no effect on mode, busy or timing.
- R5: Codes 02h and 14h enter command mode at once. The counters are held at zero, both syncs are inactive, de_o is low, and cmd_mode_o is high two edges after the command edge.
- R6: Code 15h enters command mode at once with the counters and syncs still running. de_o is low and blank_o is high.
- R7: Code 12h, accepted in display mode, keeps the display running until the horizontal counter next equals h_sync_start, then enters halted command mode.
- R8: Code 11h, accepted in display mode, keeps the display running until the position h=0, v=v_sync_start, then enters halted command mode.
- R9: Code 13h, accepted in display mode, runs to the next frame-sync position. It then outputs one full frame with de_o low and blank_o high while the syncs run, and enters halted command mode at the following frame-sync position.
- R10: busy_o is high from acceptance of a deferred code (11h, 12h, 13h) until the switch takes effect, and is never high together with cmd_mode_o. Any command written while busy is ignored.
- R11: After reset both counters are zero, the mode is display, busy_o and cmd_mode_o are low and both syncs are inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_total | input | H_W | Clocks per line |
| h_sync_start | input | H_W | First count of line sync |
| h_sync_end | input | H_W | First count after line sync |
| h_disp_start | input | H_W | First count of active pixels |
| h_disp_end | input | H_W | First count after active pixels |
| v_total | input | V_W | Lines per frame |
| v_sync_start | input | V_W | First line of frame sync |
| v_sync_end | input | V_W | First line after frame sync |
| v_disp_start | input | V_W | First active line |
| v_disp_end | input | V_W | First line after active lines |
| hsync_pos | input | 1 | 1: line sync active high, 0: active low |
| vsync_pos | input | 1 | 1: frame sync active high, 0: active low |
| cmd_valid | input | 1 | Command write strobe |
| cmd_type | input | 2 | Command type; 00 is display control |
| cmd_code | input | 8 | Command code |
| hsync_o | output | 1 | Line sync |
| vsync_o | output | 1 | Frame sync |
| de_o | output | 1 | Data enable |
| blank_o | output | 1 | Pixel data forced blank |
| cmd_mode_o | output | 1 | Controller is in command mode |
| busy_o | output | 1 | Deferred switch pending |

## Verification
The bench places each deferred command at a known counter phase, right after a counter restart. It then expects the switch on one exact cycle. A design that switched at the end of the sync instead of its start, or counted the frame sync from the wrong line, would move cmd_mode_o by whole lines. The black-frame case is measured over the sixty cycles between the two frame syncs: a design that skipped the frame or let data through would show the wrong de_o or blank_o counts. A command written during a deferred wait, and commands of a foreign type, must leave the pending switch time and the display unchanged. A design that accepted them would enter command mode early or stop the display.

// File: rtl/lcd_tgen_pkg.sv
package lcd_tgen_pkg;

    typedef enum logic [2:0] {
        M_DISP    = 3'd0,
        M_WAIT_H  = 3'd1,
        M_WAIT_V  = 3'd2,
        M_WAIT_VB = 3'd3,
        M_BLACK   = 3'd4,
        M_HALT    = 3'd5,
        M_BLANK   = 3'd6
    } mode_t;

    localparam logic [1:0] TYPE_DISPLAY = 2'b00;

    localparam logic [7:0] C_START      = 8'h00;
    localparam logic [7:0] C_START_SYNC = 8'h01;
    localparam logic [7:0] C_HALT_NOW   = 8'h02;
    localparam logic [7:0] C_AT_VSYNC   = 8'h11;
    localparam logic [7:0] C_AT_HSYNC   = 8'h12;
    localparam logic [7:0] C_BLACK_FRM  = 8'h13;
    localparam logic [7:0] C_HALT_ANY   = 8'h14;
    localparam logic [7:0] C_BLANK_RUN  = 8'h15;

    typedef struct packed {
        logic hs;
        logic vs;
        logic de;
        logic blank;
        logic cmd;
        logic busy;
    } tg_out_t;

    function automatic logic is_busy(mode_t m);
        return (m == M_WAIT_H) || (m == M_WAIT_V) || (m == M_WAIT_VB) || (m == M_BLACK);
    endfunction

    function automatic logic is_cmd(mode_t m);
        return (m == M_HALT) || (m == M_BLANK);
    endfunction

    function automatic logic shows_data(mode_t m);
        return (m == M_DISP) || (m == M_WAIT_H) || (m == M_WAIT_V) || (m == M_WAIT_VB);
    endfunction

endpackage

// File: rtl/lcd_tgen_axis.sv
module lcd_tgen_axis #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         adv,
    input  logic [W-1:0] total,
    input  logic [W-1:0] sync_s,
    input  logic [W-1:0] sync_e,
    input  logic [W-1:0] disp_s,
    input  logic [W-1:0] disp_e,
    output logic [W-1:0] cnt,
    output logic         sync_act,
    output logic         win_act
);
    logic at_last;

    assign at_last  = (cnt == total - W'(1));
    assign sync_act = (cnt >= sync_s) && (cnt < sync_e);
    assign win_act  = (cnt >= disp_s) && (cnt < disp_e);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (adv) begin
            cnt <= at_last ? '0 : cnt + W'(1);
        end
    end
endmodule

// File: rtl/lcd_tgen_mode.sv
module lcd_tgen_mode
    import lcd_tgen_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_type,
    input  logic [7:0] cmd_code,
    input  logic       h_ev,
    input  logic       v_ev,
    output mode_t      mode,
    output logic       restart
);
    mode_t mode_n;
    logic  accept;

    assign accept = cmd_valid && (cmd_type == TYPE_DISPLAY) && !is_busy(mode);

    always_comb begin
        mode_n  = mode;
        restart = 1'b0;
        if (accept) begin
            case (cmd_code)
                C_START:      mode_n = M_DISP;
                C_START_SYNC: begin
                    mode_n  = M_DISP;
                    restart = 1'b1;
                end
                C_HALT_NOW,
                C_HALT_ANY:   mode_n = M_HALT;
                C_BLANK_RUN:  mode_n = M_BLANK;
                C_AT_VSYNC:   if (mode == M_DISP) mode_n = M_WAIT_V;
                C_AT_HSYNC:   if (mode == M_DISP) mode_n = M_WAIT_H;
                C_BLACK_FRM:  if (mode == M_DISP) mode_n = M_WAIT_VB;
                default:      mode_n = mode;
            endcase
        end else begin
            case (mode)
                M_WAIT_H:  if (h_ev) mode_n = M_HALT;
                M_WAIT_V:  if (v_ev) mode_n = M_HALT;
                M_WAIT_VB: if (v_ev) mode_n = M_BLACK;
                M_BLACK:   if (v_ev) mode_n = M_HALT;
                default:   mode_n = mode;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) mode <= M_DISP;
        else     mode <= mode_n;
    end
endmodule

// File: rtl/lcd_tgen_out.sv
module lcd_tgen_out
    import lcd_tgen_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  mode_t   mode,
    input  logic    h_sync_act,
    input  logic    v_sync_act,
    input  logic    in_window,
    input  logic    hsync_pos,
    input  logic    vsync_pos,
    output tg_out_t q
);
    tg_out_t d;
    logic    run;

    assign run = (mode != M_HALT);

    always_comb begin
        d.hs    = hsync_pos ? (h_sync_act && run) : !(h_sync_act && run);
        d.vs    = vsync_pos ? (v_sync_act && run) : !(v_sync_act && run);
        d.de    = in_window && shows_data(mode);
        d.blank = (mode == M_BLACK) || (mode == M_BLANK);
        d.cmd   = is_cmd(mode);
        d.busy  = is_busy(mode);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q       <= '0;
            q.hs    <= !hsync_pos;
            q.vs    <= !vsync_pos;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/lcd_tgen.sv
module lcd_tgen
    import lcd_tgen_pkg::*;
#(
    parameter int H_W = 12,
    parameter int V_W = 11
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [H_W-1:0] h_total,
    input  logic [H_W-1:0] h_sync_start,
    input  logic [H_W-1:0] h_sync_end,
    input  logic [H_W-1:0] h_disp_start,
    input  logic [H_W-1:0] h_disp_end,
    input  logic [V_W-1:0] v_total,
    input  logic [V_W-1:0] v_sync_start,
    input  logic [V_W-1:0] v_sync_end,
    input  logic [V_W-1:0] v_disp_start,
    input  logic [V_W-1:0] v_disp_end,
    input  logic           hsync_pos,
    input  logic           vsync_pos,
    input  logic           cmd_valid,
    input  logic [1:0]     cmd_type,
    input  logic [7:0]     cmd_code,
    output logic           hsync_o,
    output logic           vsync_o,
    output logic           de_o,
    output logic           blank_o,
    output logic           cmd_mode_o,
    output logic           busy_o
);
    mode_t          mode_q;
    logic           restart;
    logic           cnt_clr;
    logic [H_W-1:0] h_cnt;
    logic [V_W-1:0] v_cnt;
    logic           h_last;
    logic           h_sync_act, v_sync_act;
    logic           h_win, v_win;
    logic           h_ev, v_ev;
    tg_out_t        oq;

    assign cnt_clr = (mode_q == M_HALT) || restart;
    assign h_last  = (h_cnt == h_total - H_W'(1));
    assign h_ev    = (h_cnt == h_sync_start);
    assign v_ev    = (h_cnt == '0) && (v_cnt == v_sync_start);

    lcd_tgen_axis #(.W(H_W)) i_h_axis (
        .clk(clk), .rst(rst), .clr(cnt_clr), .adv(1'b1),
        .total(h_total), .sync_s(h_sync_start), .sync_e(h_sync_end),
        .disp_s(h_disp_start), .disp_e(h_disp_end),
        .cnt(h_cnt), .sync_act(h_sync_act), .win_act(h_win)
    );

    lcd_tgen_axis #(.W(V_W)) i_v_axis (
        .clk(clk), .rst(rst), .clr(cnt_clr), .adv(h_last),
        .total(v_total), .sync_s(v_sync_start), .sync_e(v_sync_end),
        .disp_s(v_disp_start), .disp_e(v_disp_end),
        .cnt(v_cnt), .sync_act(v_sync_act), .win_act(v_win)
    );

    lcd_tgen_mode i_mode (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_type(cmd_type), .cmd_code(cmd_code),
        .h_ev(h_ev), .v_ev(v_ev),
        .mode(mode_q), .restart(restart)
    );

    lcd_tgen_out i_out (
        .clk(clk), .rst(rst), .mode(mode_q),
        .h_sync_act(h_sync_act), .v_sync_act(v_sync_act),
        .in_window(h_win && v_win),
        .hsync_pos(hsync_pos), .vsync_pos(vsync_pos),
        .q(oq)
    );

    assign hsync_o    = oq.hs;
    assign vsync_o    = oq.vs;
    assign de_o       = oq.de;
    assign blank_o    = oq.blank;
    assign cmd_mode_o = oq.cmd;
    assign busy_o     = oq.busy;
endmodule

// File: rtl/lcd_tgen_chk.sv
module lcd_tgen_chk
    import lcd_tgen_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       cmd_valid,
    input logic [1:0] cmd_type,
    input logic [2:0] mode_bits,
    input logic       de_o,
    input logic       blank_o,
    input logic       cmd_mode_o,
    input logic       busy_o
);
    logic settled_mode;
    assign settled_mode = (mode_bits == M_DISP) || (mode_bits == M_HALT) || (mode_bits == M_BLANK);

    p_busy_excl_cmd_r10: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> !cmd_mode_o);

    p_busy_ends_cmd_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> cmd_mode_o);

    p_cmd_no_de_r5: assert property (@(posedge clk) disable iff (rst)
        cmd_mode_o |-> !de_o);

    p_blank_no_de_r6: assert property (@(posedge clk) disable iff (rst)
        blank_o |-> !de_o);

    p_foreign_type_r4: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_type != TYPE_DISPLAY && settled_mode) |=> $stable(mode_bits));
endmodule

bind lcd_tgen lcd_tgen_chk i_chk (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_type(cmd_type),
    .mode_bits(mode_q), .de_o(de_o), .blank_o(blank_o),
    .cmd_mode_o(cmd_mode_o), .busy_o(busy_o)
);

// File: tb/test_lcd_tgen.sv
`timescale 1ns/1ps
module test_lcd_tgen;
    localparam int H_W = 12;
    localparam int V_W = 11;
    localparam int S_HS = 0, S_VS = 1, S_DE = 2, S_BL = 3, S_CM = 4, S_BZ = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hsync_pos = 1'b0, vsync_pos = 1'b0;
    logic cmd_valid = 1'b0;
    logic [1:0] cmd_type = 2'b00;
    logic [7:0] cmd_code = 8'h00;
    logic hsync_o, vsync_o, de_o, blank_o, cmd_mode_o, busy_o;

    int cyc = 0;
    int n_checks = 0;
    int n_fail = 0;

    typedef struct {int cyc; int sig; int val; string req;} exp_t;
    exp_t sbq[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    lcd_tgen #(.H_W(H_W), .V_W(V_W)) i_lcd_tgen (
        .clk(clk), .rst(rst),
        .h_total(12'd10), .h_sync_start(12'd1), .h_sync_end(12'd3),
        .h_disp_start(12'd4), .h_disp_end(12'd9),
        .v_total(11'd6), .v_sync_start(11'd1), .v_sync_end(11'd2),
        .v_disp_start(11'd3), .v_disp_end(11'd5),
        .hsync_pos(hsync_pos), .vsync_pos(vsync_pos),
        .cmd_valid(cmd_valid), .cmd_type(cmd_type), .cmd_code(cmd_code),
        .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o), .blank_o(blank_o),
        .cmd_mode_o(cmd_mode_o), .busy_o(busy_o)
    );

    function automatic int sig_val(int s);
        case (s)
            S_HS: return int'(hsync_o);
            S_VS: return int'(vsync_o);
            S_DE: return int'(de_o);
            S_BL: return int'(blank_o);
            S_CM: return int'(cmd_mode_o);
            default: return int'(busy_o);
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push(input int c, input int s, input int v, input string r);
        exp_t e;
        e.cyc = c; e.sig = s; e.val = v; e.req = r;
        sbq.push_back(e);
    endtask

    // monitor: compare scoreboard items at their cycle
    always @(negedge clk) begin
        exp_t e;
        while (sbq.size() > 0 && sbq[0].cyc <= cyc) begin
            e = sbq.pop_front();
            if (e.cyc < cyc)
                chk(1'b0, {e.req, " (missed slot)"}, cyc, e.cyc);
            else
                chk(sig_val(e.sig) == e.val, $sformatf("%s sig%0d@%0d", e.req, e.sig, e.cyc),
                    sig_val(e.sig), e.val);
        end
    end

    task automatic send(input logic [1:0] t, input logic [7:0] c, output int e);
        cmd_valid = 1'b1; cmd_type = t; cmd_code = c;
        @(posedge clk); #1 e = cyc;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_type = 2'b00; cmd_code = 8'h00;
    endtask

    task automatic wait_cyc(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic measure(input int n, output int hs_lo, output int vs_lo,
                           output int de_hi, output int bl_hi);
        hs_lo = 0; vs_lo = 0; de_hi = 0; bl_hi = 0;
        repeat (n) begin
            @(negedge clk);
            if (!hsync_o) hs_lo++;
            if (!vsync_o) vs_lo++;
            if (de_o) de_hi++;
            if (blank_o) bl_hi++;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog all-reqs actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        int e, e0, e1, e2, hs, vs, de, bl;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R11 reset state
        chk(cmd_mode_o == 1'b0, "R11 cmd_mode", cmd_mode_o, 0);
        chk(busy_o == 1'b0, "R11 busy", busy_o, 0);
        chk(de_o == 1'b0, "R11 de", de_o, 0);
        chk(hsync_o == 1'b1 && vsync_o == 1'b1, "R11 syncs inactive", {hsync_o, vsync_o}, 3);

        // R1 / R2 frame counts: 10x6 frame, 5x2 active, 2-clock line sync, 1-line frame sync
        measure(60, hs, vs, de, bl);
        chk(hs == 12, "R2 hsync active cycles", hs, 12);
        chk(vs == 10, "R2 vsync active cycles", vs, 10);
        chk(de == 10, "R1 de cycles per frame", de, 10);
        chk(bl == 0, "R1 no blank in display", bl, 0);

        // R2 polarity select
        hsync_pos = 1'b1;
        @(negedge clk);
        measure(60, hs, vs, de, bl);
        chk(hs == 48, "R2 hsync active-high low count", hs, 48);
        chk(vs == 10, "R2 vsync still active-low", vs, 10);
        hsync_pos = 1'b0;
        @(negedge clk); @(negedge clk);

        // R4 foreign types ignored
        send(2'b01, 8'h02, e);
        push(e + 2, S_CM, 0, "R4");
        push(e + 2, S_BZ, 0, "R4");
        send(2'b11, 8'h14, e);
        push(e + 2, S_CM, 0, "R4");
        measure(60, hs, vs, de, bl);
        chk(de == 10, "R4 display unchanged", de, 10);

        // R5 immediate halt
        send(2'b00, 8'h02, e);
        push(e + 2, S_CM, 1, "R5");
        push(e + 2, S_DE, 0, "R5");
        push(e + 2, S_HS, 1, "R5");
        wait_cyc(e + 2);
        measure(60, hs, vs, de, bl);
        chk(hs == 0 && vs == 0, "R5 syncs idle", hs + vs, 0);
        chk(de == 0, "R5 no de", de, 0);

        // R3 start from zero
        send(2'b00, 8'h00, e);
        push(e + 1, S_HS, 1, "R3");
        push(e + 2, S_CM, 0, "R3");
        push(e + 2, S_HS, 0, "R3");
        push(e + 4, S_HS, 1, "R3");
        push(e + 10, S_VS, 1, "R3");
        push(e + 11, S_VS, 0, "R3");
        wait_cyc(e + 12);

        // R6 blank-running command mode
        send(2'b00, 8'h15, e);
        push(e + 2, S_CM, 1, "R6");
        push(e + 2, S_BL, 1, "R6");
        wait_cyc(e + 2);
        measure(60, hs, vs, de, bl);
        chk(hs == 12, "R6 hsync keeps running", hs, 12);
        chk(de == 0, "R6 no de", de, 0);
        chk(bl == 60, "R6 blank held", bl, 60);

        // R3 frame-synchronised start clears counters
        send(2'b00, 8'h01, e0);
        push(e0 + 2, S_CM, 0, "R3");
        push(e0 + 2, S_BL, 0, "R3");
        push(e0 + 10, S_VS, 1, "R3");
        push(e0 + 11, S_VS, 0, "R3");

        // R7 switch at line sync (issued at counter 19: h=9 v=1)
        wait_cyc(e0 + 19);
        send(2'b00, 8'h12, e1);
        push(e1 + 1, S_BZ, 1, "R10");
        push(e1 + 1, S_CM, 0, "R7");
        push(e1 + 2, S_BZ, 1, "R7");
        push(e1 + 2, S_HS, 0, "R7");
        push(e1 + 3, S_BZ, 0, "R10");
        push(e1 + 3, S_CM, 1, "R7");
        wait_cyc(e1 + 4);

        // R8 switch at frame sync, with an ignored command while busy (R10)
        send(2'b00, 8'h00, e0);
        wait_cyc(e0 + 19);
        send(2'b00, 8'h11, e1);
        push(e1 + 1, S_BZ, 1, "R10");
        wait_cyc(e1 + 2);
        send(2'b00, 8'h02, e2);
        push(e2 + 2, S_CM, 0, "R10");
        push(e1 + 51, S_BZ, 1, "R8");
        push(e1 + 51, S_CM, 0, "R8");
        push(e1 + 51, S_VS, 0, "R8");
        push(e1 + 52, S_CM, 1, "R8");
        push(e1 + 52, S_BZ, 0, "R8");
        wait_cyc(e1 + 53);

        // R9 black frame before the switch
        send(2'b00, 8'h00, e0);
        wait_cyc(e0 + 19);
        send(2'b00, 8'h13, e1);
        push(e1 + 1, S_BZ, 1, "R9");
        push(e1 + 51, S_BZ, 1, "R9");
        push(e1 + 51, S_BL, 0, "R9");
        push(e1 + 52, S_BL, 1, "R9");
        push(e1 + 52, S_BZ, 1, "R9");
        push(e1 + 52, S_CM, 0, "R9");
        push(e1 + 111, S_BL, 1, "R9");
        push(e1 + 111, S_BZ, 1, "R9");
        push(e1 + 112, S_CM, 1, "R9");
        push(e1 + 112, S_BZ, 0, "R9");
        push(e1 + 112, S_BL, 0, "R9");
        wait_cyc(e1 + 51);
        measure(60, hs, vs, de, bl);
        chk(de == 0, "R9 black frame no de", de, 0);
        chk(bl == 60, "R9 black frame blank", bl, 60);
        chk(hs == 12, "R9 syncs run in black frame", hs, 12);
        wait_cyc(e1 + 113);

        // R5 halt regardless of position
        send(2'b00, 8'h00, e);
        wait_cyc(e + 7);
        send(2'b00, 8'h14, e);
        push(e + 2, S_CM, 1, "R5");
        wait_cyc(e + 3);

        @(negedge clk);
        chk(sbq.size() == 0, "scoreboard drained", sbq.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule